// File: doc/BRIEF.md
# USB IN-Endpoint Transmit Control Byte

This block holds the per-endpoint transmit control and status byte of a USB device controller. A CPU writes and reads the byte over a simple register port. A packet engine, which answers IN tokens, reports its events to the block as single-cycle strobes. The block keeps four control bits: packet ready, flush, send stall and clear toggle. It also keeps four status bits: FIFO not empty, underrun, stall sent and incomplete receive. Beside the byte it tracks the endpoint's DATA0/DATA1 toggle and a packet occupancy count of up to two slots, which serves the optional double-buffered FIFO. It raises a one-cycle interrupt pulse when a packet goes out or when a flush is requested.

No data stream passes through this block, so it has no valid/ready interface. All event inputs are one-cycle strobes. The block accepts one of each in every cycle and never stalls its sources. Register writes also take effect in one cycle, with no handshake. The double-buffer mode select and the high-bandwidth mode select are plain level inputs. The mode select should only change while the endpoint holds no packets.

Top module: `ep_tx_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `data_toggle`, `send_stall`, `fifo_flush` and `irq` are all 0.
- R2: In single-buffer mode (`dbl_buf`=0), a write with bit 0 set loads one packet. `rd_data` then reads 0x03, meaning packet ready (bit 0) and FIFO not empty (bit 1). A further write of bit 0 while the packet is held adds no second packet.
- R3: A `pkt_sent` strobe while a packet is held has three effects. It removes one packet, which clears bit 0, and clears bit 1 once no packet remains. It inverts `data_toggle`. It pulses `irq` for exactly one cycle. The effects show in the cycle after the strobe. A `pkt_sent` strobe with no packet held has no effect.
- R4: In double-buffer mode (`dbl_buf`=1), up to two packets can be held. After the first load, bit 0 stays 0 and bit 1 reads 1, so software can load a second packet. After the second load, bit 0 reads 1. A third load is ignored. Each transmission removes one packet and leaves bit 0 at 0.
- R5: A write with bit 3 (flush) set discards the most recent packet, if there is one, which clears packet ready. It pulses both `fifo_flush` and `irq` for one cycle, even when the FIFO is empty. Bit 3 reads back as 0. A packet load (bit 0) in the same write is ignored.
- R6: An `in_token` strobe with no packet held and stall off sets the underrun flag (bit 2). Writing 1 to bit 2 leaves the flag unchanged and writing 0 clears it. A set event in the same cycle as a clearing write wins.
- R7: Bit 4 is a plain read/write bit that drives `send_stall`. An `in_token` while it is 1 does not set underrun. A `stall_sent_evt` strobe sets the stall-sent flag (bit 5), which clears only on a write of 0.
- R8: A write with bit 6 set forces `data_toggle` to 0, even when a transmission in the same cycle would invert it. Bit 6 reads back as 0.
- R9: The incomplete-receive flag (bit 7) is set by `incomp_evt` only while `iso_hb`=1. It reads 0 whenever `iso_hb`=0. It is cleared by writing 0 to bit 7, and writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_buf | input | 1 | 1 selects two-slot double-buffered operation |
| iso_hb | input | 1 | 1 while the endpoint runs high-bandwidth isochronous or interrupt transfers |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register byte |
| in_token | input | 1 | Strobe: IN token received for this endpoint |
| pkt_sent | input | 1 | Strobe: data packet transmitted |
| stall_sent_evt | input | 1 | Strobe: STALL handshake transmitted |
| incomp_evt | input | 1 | Strobe: part of a packet was not received |
| send_stall | output | 1 | Endpoint must answer IN tokens with STALL |
| data_toggle | output | 1 | Data PID to use next (0 = DATA0) |
| fifo_flush | output | 1 | One-cycle pulse: drop the newest packet and reset the FIFO pointer |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong slot count shows up at the ports in two ways. The packet-ready and not-empty bits read wrongly in the very next cycle. A count that drifts high or low also shows later, when a transmission fails to empty the FIFO or a load is refused. A lost or mis-prioritised flag event leaves the status bit at 0 one cycle after the strobe. A toggle error shows on `data_toggle` one cycle after `pkt_sent` or the clear write. For this reason every scenario samples the byte one cycle after each stimulus, and then again after the following transmissions.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
  localparam int CSR_W     = 8;
  localparam int B_READY   = 0;
  localparam int B_NEMPTY  = 1;
  localparam int B_UNDER   = 2;
  localparam int B_FLUSH   = 3;
  localparam int B_STALL   = 4;
  localparam int B_SSENT   = 5;
  localparam int B_CLRTGL  = 6;
  localparam int B_INCOMP  = 7;
endpackage

// File: rtl/ep_tx_w0c_flag.sv
// Status flag: set by hardware, cleared by a bus write of 0; set wins.
module ep_tx_w0c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic wr_clr,
  input  logic hw_set,
  output logic flag
);
  logic flag_nx;

  always_comb begin
    flag_nx = flag;
    if (!enable)     flag_nx = 1'b0;
    else if (hw_set) flag_nx = 1'b1;
    else if (wr_clr) flag_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nx;
  end
endmodule

// File: rtl/ep_tx_slot_ctr.sv
// Packet occupancy count and the derived packet-ready state.
module ep_tx_slot_ctr #(
  parameter int SLOT_MAX = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl_buf,
  input  logic set_req,
  input  logic flush_req,
  input  logic sent_evt,
  output logic pkt_ready,
  output logic not_empty,
  output logic sent_ok
);
  localparam int CNT_W = $clog2(SLOT_MAX + 1);

  logic [CNT_W-1:0] slots, cap, after_sent, slots_nx;
  logic             flush_ok, set_ok;

  always_comb begin
    cap        = dbl_buf ? CNT_W'(SLOT_MAX) : CNT_W'(1);
    sent_ok    = sent_evt && (slots != '0);
    after_sent = slots - CNT_W'(sent_ok);
    flush_ok   = flush_req && (after_sent != '0);
    set_ok     = set_req && !flush_req && (slots < cap);
    slots_nx   = after_sent - CNT_W'(flush_ok) + CNT_W'(set_ok);
  end

  assign pkt_ready = (slots >= cap);
  assign not_empty = (slots != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slots <= '0;
    else        slots <= slots_nx;
  end
endmodule

// File: rtl/ep_tx_toggle.sv
// Endpoint DATA0/DATA1 toggle; a clear beats a flip.
module ep_tx_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic flip,
  output logic tgl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tgl <= 1'b0;
    else if (clear) tgl <= 1'b0;
    else if (flip)  tgl <= ~tgl;
  end
endmodule

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl
  import ep_tx_pkg::*;
#(
  parameter int SLOT_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl_buf,
  input  logic             iso_hb,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             in_token,
  input  logic             pkt_sent,
  input  logic             stall_sent_evt,
  input  logic             incomp_evt,
  output logic             send_stall,
  output logic             data_toggle,
  output logic             fifo_flush,
  output logic             irq
);
  localparam int NFLAG = 3;

  logic wr_load, wr_flush, wr_clrt;
  logic pkt_ready, not_empty, sent_ok;
  logic stall_q, irq_q, flush_q;
  logic [NFLAG-1:0] f_en, f_clr, f_set, f_q;
  logic unused_wr_bit;

  assign wr_load  = wr_en && wr_data[B_READY];
  assign wr_flush = wr_en && wr_data[B_FLUSH];
  assign wr_clrt  = wr_en && wr_data[B_CLRTGL];
  assign unused_wr_bit = wr_data[B_NEMPTY];

  ep_tx_slot_ctr #(.SLOT_MAX(SLOT_MAX)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbl_buf   (dbl_buf),
    .set_req   (wr_load),
    .flush_req (wr_flush),
    .sent_evt  (pkt_sent),
    .pkt_ready (pkt_ready),
    .not_empty (not_empty),
    .sent_ok   (sent_ok)
  );

  ep_tx_toggle u_tgl (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wr_clrt),
    .flip  (sent_ok),
    .tgl   (data_toggle)
  );

  // flag 0: underrun, 1: stall sent, 2: incomplete receive
  assign f_en  = {iso_hb, 1'b1, 1'b1};
  assign f_clr = {wr_en && !wr_data[B_INCOMP],
                  wr_en && !wr_data[B_SSENT],
                  wr_en && !wr_data[B_UNDER]};
  assign f_set = {incomp_evt, stall_sent_evt, in_token && !stall_q && !not_empty};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ep_tx_w0c_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (f_en[g]),
      .wr_clr (f_clr[g]),
      .hw_set (f_set[g]),
      .flag   (f_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      irq_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (wr_en) stall_q <= wr_data[B_STALL];
      irq_q   <= sent_ok || wr_flush;
      flush_q <= wr_flush;
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[B_READY]  = pkt_ready;
    rd_data[B_NEMPTY] = not_empty;
    rd_data[B_UNDER]  = f_q[0];
    rd_data[B_STALL]  = stall_q;
    rd_data[B_SSENT]  = f_q[1];
    rd_data[B_INCOMP] = f_q[2] && iso_hb;
  end

  assign send_stall = stall_q;
  assign irq        = irq_q;
  assign fifo_flush = flush_q;
endmodule

// File: rtl/ep_tx_ctrl_chk.sv
module ep_tx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iso_hb,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       in_token,
  input logic       pkt_sent,
  input logic       stall_sent_evt,
  input logic       send_stall,
  input logic       data_toggle,
  input logic       fifo_flush
);
  AST_READY_HAS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> rd_data[1]); // R2
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && rd_data[1] && !(wr_en && wr_data[6])) |=> (data_toggle != $past(data_toggle))); // R3
  AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_flush) |-> $past(wr_en && wr_data[3])); // R5
  AST_UNDERRUN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !send_stall && !rd_data[1]) |=> rd_data[2]); // R6
  AST_W1_KEEPS_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2] && rd_data[2]) |=> rd_data[2]); // R6
  AST_STALL_SENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent_evt |=> rd_data[5]); // R7
  AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6]) |=> !data_toggle); // R8
  AST_INCOMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_hb |-> !rd_data[7]); // R9
endmodule

bind ep_tx_ctrl ep_tx_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .iso_hb         (iso_hb),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .in_token       (in_token),
  .pkt_sent       (pkt_sent),
  .stall_sent_evt (stall_sent_evt),
  .send_stall     (send_stall),
  .data_toggle    (data_toggle),
  .fifo_flush     (fifo_flush)
);

// File: tb/test_ep_tx_ctrl.sv
module test_ep_tx_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dbl_buf = 1'b0, iso_hb = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       in_token = 1'b0, pkt_sent = 1'b0, stall_sent_evt = 1'b0, incomp_evt = 1'b0;
  logic       send_stall, data_toggle, fifo_flush, irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ep_tx_ctrl i_ep_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .dbl_buf(dbl_buf), .iso_hb(iso_hb),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .in_token(in_token), .pkt_sent(pkt_sent), .stall_sent_evt(stall_sent_evt),
    .incomp_evt(incomp_evt), .send_stall(send_stall), .data_toggle(data_toggle),
    .fifo_flush(fifo_flush), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dbl_buf = 1'b0; iso_hb = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    in_token = 1'b0; pkt_sent = 1'b0; stall_sent_evt = 1'b0; incomp_evt = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic send();
    pkt_sent = 1'b1;
    @(negedge clk);
    pkt_sent = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 pins", {4'b0, data_toggle, send_stall, fifo_flush, irq}, 8'h00);
  endtask

  task automatic t_single();
    do_reset();
    wr(8'h01);
    check("R2 first load", rd_data, 8'h03);
    wr(8'h01);
    check("R2 second load", rd_data, 8'h03);
    send();
    check("R3 after send", rd_data, 8'h00);
    check("R3 irq+toggle", {6'b0, irq, data_toggle}, 8'h03);
    @(negedge clk);
    check("R3 irq one cycle", {7'b0, irq}, 8'h00);
    send();
    check("R3 empty send ignored", {rd_data[1:0], 4'b0, irq, data_toggle}, 8'h01);
  endtask

  task automatic t_double();
    do_reset();
    dbl_buf = 1'b1;
    wr(8'h01);
    check("R4 one held", rd_data, 8'h02);
    wr(8'h01);
    check("R4 two held", rd_data, 8'h03);
    wr(8'h01);
    check("R4 third ignored", rd_data, 8'h03);
    send();
    check("R4 one left", {rd_data[1:0], 5'b0, data_toggle}, 8'h81);
    send();
    check("R4 empty", {rd_data[1:0], 5'b0, data_toggle}, 8'h00);
  endtask

  task automatic t_flush();
    do_reset();
    dbl_buf = 1'b1;
    wr(8'h01);
    wr(8'h01);
    wr(8'h09);
    check("R5 flush drops one, load ignored", rd_data, 8'h02);
    check("R5 pulses", {6'b0, fifo_flush, irq}, 8'h03);
    @(negedge clk);
    check("R5 pulses end", {6'b0, fifo_flush, irq}, 8'h00);
    wr(8'h08);
    check("R5 flush last", rd_data, 8'h00);
    wr(8'h08);
    check("R5 flush empty pulses", {rd_data[1:0], 4'b0, fifo_flush, irq}, 8'h03);
  endtask

  task automatic t_underrun();
    do_reset();
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    check("R6 set", rd_data, 8'h04);
    wr(8'h04);
    check("R6 write 1 keeps", rd_data, 8'h04);
    wr(8'h00);
    check("R6 write 0 clears", rd_data, 8'h00);
    in_token = 1'b1;
    wr(8'h00);
    in_token = 1'b0;
    check("R6 set beats clear", rd_data, 8'h04);
  endtask

  task automatic t_stall();
    do_reset();
    wr(8'h10);
    check("R7 stall on", {rd_data[7:1], send_stall}, 8'h11);
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    check("R7 no underrun while stalled", rd_data, 8'h10);
    stall_sent_evt = 1'b1;
    @(negedge clk);
    stall_sent_evt = 1'b0;
    check("R7 stall sent", rd_data, 8'h30);
    wr(8'h10);
    check("R7 stall sent cleared", rd_data, 8'h10);
    wr(8'h00);
    check("R7 stall off", {rd_data[7:1], send_stall}, 8'h00);
  endtask

  task automatic t_toggle();
    do_reset();
    wr(8'h01);
    send();
    check("R8 toggled first", {7'b0, data_toggle}, 8'h01);
    wr(8'h40);
    check("R8 cleared", {rd_data[7:1], data_toggle}, 8'h00);
    wr(8'h01);
    send();
    wr(8'h01);
    pkt_sent = 1'b1;
    wr(8'h40);
    pkt_sent = 1'b0;
    check("R8 clear beats flip", {rd_data[7:1], data_toggle}, 8'h00);
  endtask

  task automatic t_incomp();
    do_reset();
    incomp_evt = 1'b1;
    @(negedge clk);
    incomp_evt = 1'b0;
    check("R9 ignored off mode", rd_data, 8'h00);
    iso_hb = 1'b1;
    incomp_evt = 1'b1;
    @(negedge clk);
    incomp_evt = 1'b0;
    check("R9 set", rd_data, 8'h80);
    wr(8'h80);
    check("R9 write 1 keeps", rd_data, 8'h80);
    wr(8'h00);
    check("R9 write 0 clears", rd_data, 8'h00);
  endtask

  initial begin
    t_reset();
    t_single();
    t_double();
    t_flush();
    t_underrun();
    t_stall();
    t_toggle();
    t_incomp();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule